// File: doc/BRIEF.md
# Line Sync Pulse and Back-Porch Gate Generator

This block works on a sync signal that has already been turned into a logic level. The input is active low and carries every sync pulse of the video, including the extra half-line pulses of field blanking. The block is clocked by a free-running sample clock. Its first output is a horizontal sync pulse of fixed width, produced once per video line. It starts one line pulse on the leading (falling) edge of each accepted sync pulse. A falling edge that comes too soon after the last accepted one is dropped, so the half-line pulses of field blanking give no extra line pulses.

Its second output is an active-low gate that opens a short, fixed delay after every trailing (rising) sync edge. This gate can drive an external black-level clamp during the back porch. Every interval is a parameter counted in clock cycles. The acceptance window is derived from the line period, so all timing follows one time base. The input first passes through a two-flop synchroniser and a glitch filter.

Top module: `hsep_top`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, both outputs are high (inactive).
- R2: An accepted falling sync edge drives `hsync_n_o` low on the (2+GLITCH_CYC)th rising clock edge after the edge that first samples the low input. It stays low for exactly HS_W_CYC cycles.
- R3: A falling edge is accepted only if at least MIN_GAP = LINE_CYC*3/4 cycles (integer division) separate it from the last accepted falling edge. An edge at MIN_GAP is accepted and an edge at MIN_GAP-1 is rejected. A rejected edge does not restart that interval.
- R4: A stream of sync pulses at half the line period yields one line pulse per line period, and none on the in-between pulses.
- R5: The first falling edge after reset is accepted. After a span with no accepted edge, the interval counter holds at MAX_GAP = LINE_CYC*5/4, and the next falling edge is accepted.
- R6: A low excursion on the input that lasts fewer than GLITCH_CYC sample cycles produces no change on either output. An excursion of exactly GLITCH_CYC cycles is taken as a real edge.
- R7: Each rising sync edge drives `bporch_n_o` low on the (2+GLITCH_CYC+BP_DLY_CYC)th rising clock edge after the edge that first samples the high input. It stays low for exactly BP_W_CYC cycles.
- R8: The back-porch gate fires on every trailing edge, including those of half-line pulses that give no line pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| csync_n_i | input | 1 | Composite sync level, active low, asynchronous to clk |
| hsync_n_o | output | 1 | Horizontal sync pulse, active low, one per line |
| bporch_n_o | output | 1 | Back-porch clamp gate, active low |

## Verification
Each output has a fixed latency. A line pulse is due 2+GLITCH_CYC edges after the capture of a sync fall. The clamp gate is due BP_DLY_CYC edges later than that, counted from the capture of a sync rise. The driver notes the cycle on which it changes the input. From the requirements alone it decides whether the edge is accepted, then queues the exact cycle on which each output must fall. The monitor samples on the falling clock edge and pops the queue on every observed output fall. It also measures each low time against the pulse widths. After each phase the queues must be empty, so a missing pulse and an extra pulse both count as failures.

// File: rtl/hsep_pkg.sv
// Shared types for the line sync pulse generator.
package hsep_pkg;

    // Phase of a delayed one-shot timer.
    typedef enum logic [1:0] {
        OS_IDLE   = 2'd0,
        OS_WAIT   = 2'd1,
        OS_ACTIVE = 2'd2
    } os_state_e;

endpackage

// File: rtl/hsep_sync_filter.sv
// Brings the asynchronous sync level into the clock domain with two flops.
// It then holds the level steady until the new value has been seen for
// GLITCH_CYC samples in a row, and flags filtered falling and rising edges.
// Assumes GLITCH_CYC >= 1.
module hsep_sync_filter #(
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n_i,
    output logic fall_o,
    output logic rise_o
);
    localparam int CW = $clog2(GLITCH_CYC + 1);

    logic          meta_q, samp_q;
    logic          filt_q, filt_d_q;
    logic [CW-1:0] run_q;

    // Two-flop synchroniser, idle level high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            samp_q <= 1'b1;
        end else begin
            meta_q <= raw_n_i;
            samp_q <= meta_q;
        end
    end

    // Glitch filter: adopt a new level only after GLITCH_CYC equal samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b1;
            run_q  <= '0;
        end else if (samp_q != filt_q) begin
            if (run_q == CW'(GLITCH_CYC - 1)) begin
                filt_q <= samp_q;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    // Previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) filt_d_q <= 1'b1;
        else        filt_d_q <= filt_q;
    end

    assign fall_o = filt_d_q & ~filt_q;
    assign rise_o = ~filt_d_q & filt_q;

    // R6
    filt_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != filt_d_q) |-> ($past(samp_q) == filt_q));

endmodule

// File: rtl/hsep_line_gate.sv
// Interval discriminator: it passes a falling sync edge as a line start only
// when at least MIN_GAP cycles have gone by since the last line start.
// Its interval counter holds at MAX_GAP, so after reset or a long loss of
// sync the next edge is taken at once. Assumes MIN_GAP <= MAX_GAP.
module hsep_line_gate #(
    parameter int MIN_GAP = 6000,
    parameter int MAX_GAP = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_i,
    output logic accept_o
);
    localparam int CW = $clog2(MAX_GAP + 1);

    logic [CW-1:0] since_q;

    assign accept_o = fall_i && (since_q >= CW'(MIN_GAP));

    // Interval counter: restart on a line start, otherwise count up to MAX_GAP.
    always_ff @(posedge clk) begin
        if (!rst_n)                      since_q <= CW'(MAX_GAP);
        else if (accept_o)               since_q <= CW'(1);
        else if (since_q < CW'(MAX_GAP)) since_q <= since_q + 1'b1;
    end

    // R3
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> (since_q == CW'(1)));

    // R5
    ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
        since_q <= CW'(MAX_GAP));

endmodule

// File: rtl/hsep_oneshot.sv
// Non-retriggerable one-shot. A trigger seen while idle waits DELAY_CYC
// cycles, then holds active_o high for WIDTH_CYC cycles. Triggers that come
// while it is busy are dropped. Assumes WIDTH_CYC >= 1.
module hsep_oneshot
    import hsep_pkg::*;
#(
    parameter int DELAY_CYC = 0,
    parameter int WIDTH_CYC = 625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic active_o
);
    localparam int MAXC = (DELAY_CYC > WIDTH_CYC) ? DELAY_CYC : WIDTH_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] DLY_LOAD = CW'((DELAY_CYC > 0) ? DELAY_CYC - 1 : 0);
    localparam logic [CW-1:0] W_LOAD   = CW'(WIDTH_CYC - 1);

    os_state_e     st_q;
    logic [CW-1:0] cnt_q;

    // Sequencer: idle -> (wait) -> active -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= OS_IDLE;
            cnt_q <= '0;
        end else begin
            unique case (st_q)
                OS_IDLE: if (trig_i) begin
                    if (DELAY_CYC == 0) begin
                        st_q  <= OS_ACTIVE;
                        cnt_q <= W_LOAD;
                    end else begin
                        st_q  <= OS_WAIT;
                        cnt_q <= DLY_LOAD;
                    end
                end
                OS_WAIT: if (cnt_q == '0) begin
                    st_q  <= OS_ACTIVE;
                    cnt_q <= W_LOAD;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
                OS_ACTIVE: if (cnt_q == '0) st_q <= OS_IDLE;
                           else             cnt_q <= cnt_q - 1'b1;
                default: st_q <= OS_IDLE;
            endcase
        end
    end

    assign active_o = (st_q == OS_ACTIVE);

    // Checker-side run length of the active phase.
    logic [CW:0] run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (active_o) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    // R2 R7
    width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= (CW + 1)'(WIDTH_CYC));

    // R7
    start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_o) |-> ($past(st_q) == OS_WAIT || $past(trig_i)));

endmodule

// File: rtl/hsep_top.sv
// Line sync pulse and back-porch gate generator. It takes a sync level that
// is active low and asynchronous to clk. It issues one fixed-width line pulse
// per accepted leading edge, and a delayed clamp gate after each trailing
// edge. All times are in clk cycles. Assumes HS_W_CYC < LINE_CYC*3/4.
module hsep_top #(
    parameter int LINE_CYC   = 8000,
    parameter int HS_W_CYC   = 625,
    parameter int BP_DLY_CYC = 31,
    parameter int BP_W_CYC   = 462,
    parameter int GLITCH_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic csync_n_i,
    output logic hsync_n_o,
    output logic bporch_n_o
);
    localparam int MIN_GAP = (LINE_CYC * 3) / 4;
    localparam int MAX_GAP = (LINE_CYC * 5) / 4;

    logic s_fall, s_rise, line_start, hs_act, bp_act;

    hsep_sync_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw_n_i(csync_n_i),
        .fall_o(s_fall), .rise_o(s_rise)
    );

    hsep_line_gate #(.MIN_GAP(MIN_GAP), .MAX_GAP(MAX_GAP)) u_gate (
        .clk(clk), .rst_n(rst_n), .fall_i(s_fall), .accept_o(line_start)
    );

    hsep_oneshot #(.DELAY_CYC(0), .WIDTH_CYC(HS_W_CYC)) u_hs (
        .clk(clk), .rst_n(rst_n), .trig_i(line_start), .active_o(hs_act)
    );

    hsep_oneshot #(.DELAY_CYC(BP_DLY_CYC), .WIDTH_CYC(BP_W_CYC)) u_bp (
        .clk(clk), .rst_n(rst_n), .trig_i(s_rise), .active_o(bp_act)
    );

    assign hsync_n_o  = ~hs_act;
    assign bporch_n_o = ~bp_act;

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (hsync_n_o && bporch_n_o));

    // R4
    start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |-> s_fall);

    // R2
    start_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && hsync_n_o) |=> !hsync_n_o);

endmodule

// File: tb/hsep_top_tb_top.sv
// Scoreboard bench for hsep_top.
module hsep_top_tb_top;
    localparam int LINE = 200, HSW = 20, BPD = 4, BPW = 30, G = 2;
    localparam int MIN_GAP = LINE * 3 / 4;
    localparam int LAT = 3 + G;

    logic clk = 1'b0, rst_n = 1'b0, csync_n = 1'b1;
    logic hs_n, bp_n;
    always #4 clk = ~clk;

    hsep_top #(.LINE_CYC(LINE), .HS_W_CYC(HSW), .BP_DLY_CYC(BPD),
               .BP_W_CYC(BPW), .GLITCH_CYC(G)) dut_i (
        .clk(clk), .rst_n(rst_n), .csync_n_i(csync_n),
        .hsync_n_o(hs_n), .bporch_n_o(bp_n));

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int hs_q[$], bp_q[$];
    int checks = 0, fails = 0;
    string hs_req = "R2", bp_req = "R7";
    int last_acc = 0;
    bit have_acc = 1'b0, done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Driver: one sync pulse, entered at a negedge; fall-to-fall = w + gap.
    task automatic pulse(input int w, input int gap);
        csync_n = 1'b0;
        if (!have_acc || (cyc - last_acc) >= MIN_GAP) begin
            hs_q.push_back(cyc + LAT);
            last_acc = cyc;
            have_acc = 1'b1;
        end
        repeat (w) @(negedge clk);
        csync_n = 1'b1;
        bp_q.push_back(cyc + LAT + BPD);
        repeat (gap) @(negedge clk);
    endtask

    task automatic drain();
        repeat (80) @(negedge clk);
        chk(hs_q.size() == 0, hs_req, hs_q.size(), 0);
        chk(bp_q.size() == 0, bp_req, bp_q.size(), 0);
    endtask

    // Monitor: compare output falls with queued cycles, measure widths.
    logic hs_p = 1'b1, bp_p = 1'b1;
    int hs_t0 = 0, bp_t0 = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (hs_p && !hs_n) begin
                if (hs_q.size() == 0) chk(1'b0, hs_req, cyc, -1);
                else begin
                    int e;
                    e = hs_q.pop_front();
                    chk(cyc == e, hs_req, cyc, e);
                end
                hs_t0 = cyc;
            end
            if (!hs_p && hs_n) chk(cyc - hs_t0 == HSW, "R2", cyc - hs_t0, HSW);
            if (bp_p && !bp_n) begin
                if (bp_q.size() == 0) chk(1'b0, bp_req, cyc, -1);
                else begin
                    int e;
                    e = bp_q.pop_front();
                    chk(cyc == e, bp_req, cyc, e);
                end
                bp_t0 = cyc;
            end
            if (!bp_p && bp_n) chk(cyc - bp_t0 == BPW, "R7", cyc - bp_t0, BPW);
        end
        hs_p = hs_n;
        bp_p = bp_n;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: idle outputs during and right after reset
        repeat (3) @(negedge clk);
        chk(hs_n === 1'b1, "R1", int'(hs_n), 1);
        chk(bp_n === 1'b1, "R1", int'(bp_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hs_n === 1'b1 && bp_n === 1'b1, "R1", int'({hs_n, bp_n}), 3);
        repeat (10) @(negedge clk);

        // R2 R7 R5: regular lines, first one straight after reset
        hs_req = "R2"; bp_req = "R7";
        for (int i = 0; i < 4; i++) pulse(15, LINE - 15);
        drain();

        // R4 R8: half-line pulses; only every second one starts a line
        hs_req = "R4"; bp_req = "R8";
        for (int i = 0; i < 6; i++) pulse(7, LINE / 2 - 7);
        pulse(15, LINE - 15);
        drain();

        // R3: edge at exactly MIN_GAP accepted, at MIN_GAP-1 rejected
        hs_req = "R3"; bp_req = "R7";
        pulse(15, MIN_GAP - 15);
        pulse(7, MIN_GAP - 1 - 7);
        pulse(7, 60 - 7);
        pulse(15, LINE - 15);
        drain();

        // R6: one-cycle glitch gives nothing, a GLITCH_CYC pulse is an edge
        hs_req = "R6"; bp_req = "R6";
        csync_n = 1'b0;
        @(negedge clk);
        csync_n = 1'b1;
        repeat (LINE) @(negedge clk);
        chk(hs_n === 1'b1 && bp_n === 1'b1, "R6", int'({hs_n, bp_n}), 3);
        drain();
        pulse(G, LINE);
        drain();

        // R5: long loss of sync, next edge accepted
        hs_req = "R5"; bp_req = "R7";
        repeat (3 * LINE) @(negedge clk);
        pulse(15, LINE - 15);
        pulse(15, LINE - 15);
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule